// File: doc/BRIEF.md
# Toggle-Coded Event Crossing

This block carries discrete events from one clock domain to another, unrelated one. It does not send a pulse across the boundary. In the sending domain, every cycle with the trigger high inverts a single level register. Only that one-bit level crosses into the receiving domain, where a chain of synchronizing flops samples it. A final stage compares the synchronized level with its value from the previous cycle. Each difference produces one registered strobe in the receiving domain.

Because the event travels as a change of level, it reaches the receiver however briefly the trigger was high in the sending domain. The sender must space its triggers so that the level stays stable for at least three receiving clock cycles. If two inversions fall inside one sampling window, they cancel and no strobe results. This is a known limit of the scheme. The block has no back-pressure, no acknowledge path and no data transfer. It takes a parameter for the number of synchronizing stages (two or more) and a parameter for the reset level, which every level register shares.

Top module: `evt_toggle_xing`

## Requirements
- R1: While rst_b is high, event_b is 0. After both resets are released there is no strobe until a new trigger arrives, including when the sending level had been inverted an odd number of times before the reset.
- R2: Each rising clk_a edge with trigger_a high inverts the sending level. A clk_a edge with trigger_a low leaves it unchanged. After a reset, a single trigger again yields exactly one strobe.
- R3: With single-cycle triggers spaced so that the level is stable for at least three clk_b cycles, each trigger produces exactly one event_b strobe. The receiving clock may be slower than clk_a.
- R4: When clk_b is fast enough that each inversion stays stable for at least three clk_b cycles, a trigger held high for k consecutive clk_a cycles produces exactly k strobes.
- R5: Each strobe lasts exactly one clk_b cycle. Under the spacing rule, event_b is never high in two consecutive clk_b cycles.
- R6: With two synchronizing stages, event_b first reads high after the 3rd or 4th rising clk_b edge that follows the clk_a edge registering the trigger. The one-edge uncertainty comes from sampling an asynchronous level.
- R7: Two inversions that both fall between two consecutive rising clk_b edges produce no strobe. Triggers that arrive later are still detected one for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sending-domain clock |
| rst_a | input | 1 | Sending-domain reset, asynchronous, active high |
| trigger_a | input | 1 | Event request, sampled on each rising clk_a edge |
| clk_b | input | 1 | Receiving-domain clock |
| rst_b | input | 1 | Receiving-domain reset, asynchronous, active high |
| event_b | output | 1 | One-cycle strobe per detected level change |

## Verification
Two things can coincide in one clk_b cycle: the strobe for one level change is issued while the next change is already entering the synchronizer. The bench provokes this by running clk_b only a little over three times faster than clk_a and holding trigger_a high for several consecutive clk_a cycles. Each inversion then lasts just over three clk_b cycles. The result is judged on two counts: the number of strobes must equal the number of inversions, and no strobe may stay high for two consecutive clk_b samples.

// File: rtl/evt_xing_pkg.sv
`timescale 1ns/10ps
package evt_xing_pkg;
   // fewest flops allowed between the crossing and the compare stage
   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/evt_xing_src.sv
`timescale 1ns/10ps
module evt_xing_src #(
   parameter bit INIT_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic lvl
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)       lvl <= INIT_LEVEL;
      else if (fire) lvl <= ~lvl;
   end

   // R2: a trigger inverts the level on the next edge
   assert_level_flips_R2: assert property (@(posedge clk) disable iff (rst)
      fire |=> (lvl != $past(lvl)));

   // R2: no trigger, no change
   assert_level_holds_R2: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(lvl));
endmodule

// File: rtl/evt_xing_sync.sv
`timescale 1ns/10ps
module evt_xing_sync
   import evt_xing_pkg::*;
#(
   parameter int unsigned STAGES     = 2,
   parameter bit          INIT_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("evt_xing_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[0] <= INIT_LEVEL;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[i] <= INIT_LEVEL;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/evt_xing_edge.sv
`timescale 1ns/10ps
module evt_xing_edge #(
   parameter bit INIT_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic smp,
   output logic strobe
);
   logic prev_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev_q <= INIT_LEVEL;
         strobe <= 1'b0;
      end else begin
         prev_q <= smp;
         strobe <= smp ^ prev_q;
      end
   end

   // R1: first cycle out of reset never strobes
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !strobe);

   // R5: strobe is a single cycle wide
   assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);
endmodule

// File: rtl/evt_toggle_xing.sv
`timescale 1ns/10ps
module evt_toggle_xing #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          INIT_LEVEL  = 1'b0
) (
   input  logic clk_a,
   input  logic rst_a,
   input  logic trigger_a,
   input  logic clk_b,
   input  logic rst_b,
   output logic event_b
);
   logic lvl_a;
   logic lvl_b;

   evt_xing_src #(.INIT_LEVEL(INIT_LEVEL)) u_src (
      .clk (clk_a),
      .rst (rst_a),
      .fire(trigger_a),
      .lvl (lvl_a)
   );

   evt_xing_sync #(.STAGES(SYNC_STAGES), .INIT_LEVEL(INIT_LEVEL)) u_sync (
      .clk(clk_b),
      .rst(rst_b),
      .d  (lvl_a),
      .q  (lvl_b)
   );

   evt_xing_edge #(.INIT_LEVEL(INIT_LEVEL)) u_edge (
      .clk   (clk_b),
      .rst   (rst_b),
      .smp   (lvl_b),
      .strobe(event_b)
   );

   // R3: a strobe only follows a change seen at the synchronizer output
   assert_strobe_needs_change_R3: assert property (@(posedge clk_b) disable iff (rst_b)
      event_b |-> ($past(lvl_b) != $past(lvl_b, 2)));

   // R3: every change at the synchronizer output is reported
   assert_change_gives_strobe_R3: assert property (@(posedge clk_b) disable iff (rst_b)
      ($past(lvl_b) != $past(lvl_b, 2)) |-> event_b);
endmodule

// File: tb/evt_toggle_xing_test.sv
`timescale 1ns/10ps
module evt_toggle_xing_test;
   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic rst_a = 1'b1;
   logic rst_b = 1'b1;
   logic trigger_a = 1'b0;
   logic event_b;

   realtime hb = 13.0;

   int total = 0;
   int bad   = 0;
   int ev_cnt = 0;
   int dbl    = 0;
   bit prev_hi = 1'b0;
   bit done = 1'b0;

   evt_toggle_xing uut (
      .clk_a(clk_a), .rst_a(rst_a), .trigger_a(trigger_a),
      .clk_b(clk_b), .rst_b(rst_b), .event_b(event_b)
   );

   always #10 clk_a = ~clk_a;          // 50 MHz sending clock
   always begin
      #(hb) clk_b = ~clk_b;
   end

   // strobe monitor, sampled away from the active edge
   always @(negedge clk_b) begin
      if (event_b) begin
         ev_cnt = ev_cnt + 1;
         if (prev_hi) dbl = dbl + 1;
      end
      prev_hi = event_b;
   end

   typedef struct packed {
      logic       fast;
      logic [7:0] count;
      logic [7:0] width;
      logic [7:0] gap;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'd1, 8'd1, 8'd8},
      '{1'b0, 8'd5, 8'd1, 8'd8},
      '{1'b0, 8'd3, 8'd1, 8'd12},
      '{1'b0, 8'd4, 8'd1, 8'd9},
      '{1'b1, 8'd1, 8'd1, 8'd4},
      '{1'b1, 8'd2, 8'd3, 8'd4},
      '{1'b1, 8'd1, 8'd6, 8'd4},
      '{1'b1, 8'd3, 8'd2, 8'd2}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_a(input int width);
      @(negedge clk_a);
      trigger_a = 1'b1;
      repeat (width) @(negedge clk_a);
      trigger_a = 1'b0;
   endtask

   task automatic wait_b(input int n);
      repeat (n) @(negedge clk_b);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base;
      int d0;
      int n;

      // R1: reset state
      repeat (3) @(negedge clk_b);
      check(event_b == 1'b0, "R1 event_b in reset", int'(event_b), 0);
      @(negedge clk_a); rst_a = 1'b0;
      @(negedge clk_b); rst_b = 1'b0;
      wait_b(10);
      check(ev_cnt == 0, "R1 no strobe after release", ev_cnt, 0);

      // table walk: R3 slow receiver, R4 fast receiver bursts, R5 width
      for (int v = 0; v < NV; v++) begin
         hb = VECS[v].fast ? 3.13 : 13.0;
         wait_b(6);
         base = ev_cnt;
         d0 = dbl;
         for (int c = 0; c < int'(VECS[v].count); c++) begin
            pulse_a(int'(VECS[v].width));
            repeat (int'(VECS[v].gap)) @(negedge clk_a);
         end
         wait_b(10);
         if (VECS[v].fast)
            check(ev_cnt - base == int'(VECS[v].count) * int'(VECS[v].width),
                  "R4 burst strobe count", ev_cnt - base,
                  int'(VECS[v].count) * int'(VECS[v].width));
         else
            check(ev_cnt - base == int'(VECS[v].count),
                  "R3 spaced strobe count", ev_cnt - base, int'(VECS[v].count));
         check(dbl == d0, "R5 strobe wider than one cycle", dbl - d0, 0);
      end

      // R6: latency in clk_b edges (fast receiver)
      hb = 3.13;
      wait_b(6);
      @(negedge clk_a);
      trigger_a = 1'b1;
      @(posedge clk_a);
      fork
         begin
            @(negedge clk_a);
            trigger_a = 1'b0;
         end
      join_none
      n = 0;
      while (n < 8) begin
         @(posedge clk_b);
         n++;
         #0.5;
         if (event_b) break;
      end
      check(n == 3 || n == 4, "R6 latency edges", n, 3);
      wait_b(6);

      // R7: two inversions inside one slow clk_b interval cancel
      hb = 40.0;
      wait_b(4);
      base = ev_cnt;
      @(posedge clk_b);
      @(negedge clk_a); trigger_a = 1'b1;
      @(negedge clk_a);
      @(negedge clk_a); trigger_a = 1'b0;
      wait_b(6);
      check(ev_cnt == base, "R7 cancelled pair", ev_cnt - base, 0);
      base = ev_cnt;
      pulse_a(1);
      wait_b(6);
      check(ev_cnt - base == 1, "R7 later trigger detected", ev_cnt - base, 1);

      // R1: reset with the level left inverted (odd count so far)
      hb = 13.0;
      pulse_a(1);
      wait_b(8);
      base = ev_cnt;
      @(negedge clk_a);
      rst_a = 1'b1;
      rst_b = 1'b1;
      wait_b(3);
      check(event_b == 1'b0, "R1 event_b during second reset", int'(event_b), 0);
      @(negedge clk_a); rst_a = 1'b0;
      @(negedge clk_b); rst_b = 1'b0;
      wait_b(8);
      check(ev_cnt == base, "R1 no spurious strobe", ev_cnt - base, 0);

      // R2: trigger after reset is detected once
      base = ev_cnt;
      pulse_a(1);
      wait_b(8);
      check(ev_cnt - base == 1, "R2 single trigger after reset", ev_cnt - base, 1);
      check(dbl == 0, "R5 no double-wide strobe overall", dbl, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule